// File: doc/BRIEF.md
# Key-Sequence Watchdog Timer

This block is a watchdog timer for a small 8-bit controller. It sits on a simple register bus with a one-bit address. Address 0 is a control and status register. Address 1 is a write-only restart register. The watchdog cannot be switched on or off by writing a bit. It starts only when the byte 0x1E is written to the restart register and 0xE1 is the next restart write. Writing the same pair again before the time runs out restarts the count.

The timeout length is 2^(BASE_LOG2+PS) clock cycles, where PS is the 3-bit prescaler. With the default BASE_LOG2 = 14 this runs from 16K cycles (PS = 0) to 2048K cycles (PS = 7). When the count expires, the block raises a one-cycle reset request. It does the same when a wrong byte reaches the restart register. Either event sets an overflow flag, which only software can clear.

An idle-freeze bit chooses whether the count stops while the idle input is high. There are two resets. The power-on reset clears everything. The system reset clears everything except the overflow flag, so software can read the flag after a watchdog reset.

The key checker has two states. KEY_IDLE moves to KEY_ARMED on a restart write of 0x1E; any other restart write there is a bad key and stays in KEY_IDLE. KEY_ARMED always returns to KEY_IDLE on the next restart write: 0xE1 is a valid key, anything else is a bad key.

The timer has two states. RUN_OFF moves to RUN_ON on a valid key. RUN_ON returns to RUN_OFF on expiry or on a bad key, and stays in RUN_ON, with the count cleared, on a valid key.

Top module: `wdog_seq`

## Requirements
- R1: After power-on reset, the control register reads 0x00, the restart register reads 0x00 and `wdt_rst_o` is low.
- R2: A restart write of 0x1E, followed by a restart write of 0xE1 as the next restart write, sets the enable status (control bit 0) from the cycle after the 0xE1 write.
- R3: Once enabled, `wdt_rst_o` is high for exactly one cycle, after 2^(BASE_LOG2+PS) counting cycles measured from the enabling write. In that cycle the overflow flag (control bit 1) reads 1 and the enable status reads 0.
- R4: A valid key pair written while running restarts the full timeout from the 0xE1 write.
- R5: A bad key gives a `wdt_rst_o` pulse in the cycle after the write, sets the overflow flag and clears the enable status. A bad key is any restart write other than 0x1E while not armed (0xE1 included), or any restart write other than 0xE1 while armed.
- R6: With idle-freeze (control bit 4) at 1, the count holds while `idle_i` is high. With idle-freeze at 0, the count keeps running while `idle_i` is high.
- R7: Writing the control register with bit 1 at 0 clears the overflow flag. Writing bit 1 at 1 leaves the flag unchanged. `rst_n` does not change the flag; `por_n` clears it.
- R8: `rst_n` disables the watchdog and drops an armed key state, so a lone 0xE1 written after `rst_n` is a bad key.
- R9: Control bits 7:5 hold PS and bit 4 holds idle-freeze; both read back as written. Bits 3:2 read 0, and a write to bit 0 has no effect.
- R10: Reading the restart register returns 0x00.
- R11: Control register writes between the two key bytes do not break the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears every register |
| rst_n | input | 1 | System reset, active low, asynchronous; keeps the overflow flag |
| idle_i | input | 1 | High while the CPU is in idle mode |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 = control register, 1 = restart register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| wdt_rst_o | output | 1 | One-cycle reset request |

## Verification
Register fields read back combinationally. A register write therefore shows on `bus_rdata` just after the clock edge that takes it in. A bad key raises `wdt_rst_o` one edge after the write. A timeout raises it on the edge that completes the last counting cycle, so it is high right after the clock edge that ends that cycle. The bench counts counting cycles from the edge that takes in the enabling 0xE1. It drives `idle_i` just after each rising edge, so each value applies to the following edge. It samples one time unit after every rising edge and expects the pulse exactly when its own count reaches the period, and low on the next sample.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam logic [7:0] KEY_FIRST  = 8'h1E;
    localparam logic [7:0] KEY_SECOND = 8'hE1;
    localparam logic       ADDR_CTRL    = 1'b0;
    localparam logic       ADDR_RESTART = 1'b1;

    typedef enum logic {KEY_IDLE, KEY_ARMED} key_state_t;
    typedef enum logic {RUN_OFF, RUN_ON} run_state_t;
endpackage

// File: rtl/wdog_key_fsm.sv
module wdog_key_fsm
    import wdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_i,
    input  logic [7:0] data_i,
    output logic       start_o,
    output logic       bad_o
);
    key_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (wr_i) begin
            unique case (state_q)
                KEY_IDLE:  state_d = (data_i == KEY_FIRST) ? KEY_ARMED : KEY_IDLE;
                KEY_ARMED: state_d = KEY_IDLE;
                default:   state_d = KEY_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= KEY_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        start_o = 1'b0;
        bad_o   = 1'b0;
        if (wr_i) begin
            unique case (state_q)
                KEY_IDLE:  bad_o = (data_i != KEY_FIRST);
                KEY_ARMED: begin
                    start_o = (data_i == KEY_SECOND);
                    bad_o   = (data_i != KEY_SECOND);
                end
                default:   bad_o = 1'b1;
            endcase
        end
    end

    // R5
    key_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_o || bad_o) |-> wr_i && !(start_o && bad_o));
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
    import wdog_pkg::*;
#(
    parameter int BASE_LOG2 = 14
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       bad_i,
    input  logic       freeze_i,
    input  logic [2:0] ps_i,
    output logic       run_o,
    output logic       event_o,
    output logic       rst_req_o
);
    localparam int CW = BASE_LOG2 + 8;

    run_state_t      run_q, run_d;
    logic [CW-1:0]   cnt_q, cnt_d;
    logic [CW-1:0]   last_cnt;
    logic            tick, expire;
    logic            req_q;

    assign last_cnt = ({{(CW-1){1'b0}}, 1'b1} << (BASE_LOG2 + int'(ps_i))) - 1'b1;
    assign tick     = (run_q == RUN_ON) && !freeze_i;
    assign expire   = tick && (cnt_q == last_cnt);
    assign event_o  = bad_i || expire;

    always_comb begin
        run_d = run_q;
        unique case (run_q)
            RUN_OFF: if (start_i && !bad_i) run_d = RUN_ON;
            RUN_ON:  if (bad_i || (expire && !start_i)) run_d = RUN_OFF;
            default: run_d = RUN_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= RUN_OFF;
        else        run_q <= run_d;
    end

    always_comb begin
        cnt_d = cnt_q;
        if (bad_i || start_i || expire || run_q == RUN_OFF) cnt_d = '0;
        else if (tick) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            req_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            req_q <= bad_i || (expire && !start_i);
        end
    end

    assign run_o     = (run_q == RUN_ON);
    assign rst_req_o = req_q;

    // R3
    rst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_q |=> !req_q);
    // R3
    req_disables_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_q |-> run_q == RUN_OFF);
    // R2
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !bad_i) |=> (run_q == RUN_ON && cnt_q == '0));
    // R6
    freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q == RUN_ON && freeze_i && !start_i && !bad_i) |=> cnt_q == $past(cnt_q));
endmodule

// File: rtl/wdog_ctrl_reg.sv
module wdog_ctrl_reg (
    input  logic       clk,
    input  logic       por_n,
    input  logic       rst_n,
    input  logic       wr_i,
    input  logic [2:0] ps_d_i,
    input  logic       frz_d_i,
    input  logic       ovf_keep_i,
    input  logic       set_ovf_i,
    output logic [2:0] ps_o,
    output logic       frz_o,
    output logic       ovf_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ps_o  <= 3'b000;
            frz_o <= 1'b0;
        end else if (wr_i) begin
            ps_o  <= ps_d_i;
            frz_o <= frz_d_i;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)              ovf_o <= 1'b0;
        else if (set_ovf_i)      ovf_o <= 1'b1;
        else if (wr_i && !ovf_keep_i) ovf_o <= 1'b0;
    end

    // R7
    ovf_set_chk: assert property (@(posedge clk) disable iff (!por_n)
        set_ovf_i |=> ovf_o);
endmodule

// File: rtl/wdog_seq.sv
module wdog_seq
    import wdog_pkg::*;
#(
    parameter int BASE_LOG2 = 14
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       rst_n,
    input  logic       idle_i,
    input  logic       bus_wr,
    input  logic       bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       wdt_rst_o
);
    logic       sys_rst_n;
    logic       key_wr, ctrl_wr;
    logic       key_start, key_bad;
    logic [2:0] ps;
    logic       frz, ovf, run, evt;

    assign sys_rst_n = rst_n && por_n;
    assign key_wr    = bus_wr && (bus_addr == ADDR_RESTART);
    assign ctrl_wr   = bus_wr && (bus_addr == ADDR_CTRL);

    wdog_key_fsm u_key (
        .clk     (clk),
        .rst_n   (sys_rst_n),
        .wr_i    (key_wr),
        .data_i  (bus_wdata),
        .start_o (key_start),
        .bad_o   (key_bad)
    );

    wdog_counter #(.BASE_LOG2(BASE_LOG2)) u_cnt (
        .clk       (clk),
        .rst_n     (sys_rst_n),
        .start_i   (key_start),
        .bad_i     (key_bad),
        .freeze_i  (frz && idle_i),
        .ps_i      (ps),
        .run_o     (run),
        .event_o   (evt),
        .rst_req_o (wdt_rst_o)
    );

    wdog_ctrl_reg u_ctrl (
        .clk        (clk),
        .por_n      (por_n),
        .rst_n      (sys_rst_n),
        .wr_i       (ctrl_wr),
        .ps_d_i     (bus_wdata[7:5]),
        .frz_d_i    (bus_wdata[4]),
        .ovf_keep_i (bus_wdata[1]),
        .set_ovf_i  (evt),
        .ps_o       (ps),
        .frz_o      (frz),
        .ovf_o      (ovf)
    );

    always_comb begin
        bus_rdata = 8'h00;
        if (bus_addr == ADDR_CTRL) bus_rdata = {ps, frz, 2'b00, ovf, run};
    end

    // R7
    flag_on_req_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
        wdt_rst_o |-> ovf);
    // R5
    bad_to_req_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
        key_bad |=> wdt_rst_o);
endmodule

// File: tb/wdog_seq_tb.sv
`timescale 1ns/1ps
module wdog_seq_tb;
    localparam int BL = 4;

    logic       clk = 1'b0;
    logic       por_n = 1'b0, rst_n = 1'b0, idle_i = 1'b0;
    logic       bus_wr = 1'b0, bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       wdt_rst_o;
    int         n_chk = 0, n_fail = 0;

    always #2 clk = ~clk;

    wdog_seq #(.BASE_LOG2(BL)) u_dut (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .idle_i(idle_i),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .wdt_rst_o(wdt_rst_o));

    function automatic int period(input int ps);
        return 1 << (BL + ps);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        bus_addr = a; #0.5;
        d = bus_rdata;
    endtask

    task automatic start_wd();
        wr(1'b1, 8'h1E);
        wr(1'b1, 8'hE1);
    endtask

    task automatic sys_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
    endtask

    // Count counting cycles from the enabling write and expect the pulse exactly at the period.
    task automatic run_check(input int per, input bit frz, input bit rnd, input bit idle_val, input string req);
        int act = 0;
        logic [7:0] d;
        for (int k = 0; k < 4 * per + 8 && act < per; k++) begin
            idle_i = rnd ? 1'($urandom % 2) : idle_val;
            @(posedge clk); #1;
            if (!(frz && idle_i)) act++;
            chk(wdt_rst_o == (act == per), req, wdt_rst_o, (act == per));
        end
        idle_i = 1'b0;
        chk(act == per, req, act, per);
        rd(1'b0, d);
        chk(d[1:0] == 2'b10, "R3 flag set, disabled", d[1:0], 2);
        @(posedge clk); #1;
        chk(wdt_rst_o == 1'b0, "R3 single cycle", wdt_rst_o, 0);
    endtask

    task automatic bad_check(input string req);
        logic [7:0] d;
        chk(wdt_rst_o == 1'b1, req, wdt_rst_o, 1);
        rd(1'b0, d);
        chk(d[1:0] == 2'b10, req, d[1:0], 2);
        @(posedge clk); #1;
        chk(wdt_rst_o == 1'b0, "R5 pulse ends", wdt_rst_o, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        por_n = 1'b1; rst_n = 1'b1;
        @(posedge clk); #1;

        // R1 and R10
        rd(1'b0, d); chk(d == 8'h00, "R1 ctrl reset", d, 8'h00);
        rd(1'b1, d); chk(d == 8'h00, "R10 restart reads 0", d, 8'h00);
        chk(wdt_rst_o == 1'b0, "R1 no request", wdt_rst_o, 0);

        // R9: field layout, bit 0 write ignored, bits 3:2 read 0
        wr(1'b0, 8'hFF); rd(1'b0, d);
        chk(d == 8'hF0, "R9 fields", d, 8'hF0);
        wr(1'b0, 8'hA2); rd(1'b0, d);
        chk(d == 8'hA0, "R9 fields", d, 8'hA0);
        wr(1'b0, 8'h02);

        // R2 and R11: control write between the keys
        wr(1'b1, 8'h1E);
        wr(1'b0, 8'h02);
        wr(1'b1, 8'hE1);
        rd(1'b0, d); chk(d[0] == 1'b1, "R2 R11 enabled", d[0], 1);
        run_check(period(0), 1'b0, 1'b0, 1'b0, "R3 timeout ps0");

        // R7: write 1 keeps, write 0 clears, rst_n keeps
        wr(1'b0, 8'h02); rd(1'b0, d); chk(d[1] == 1'b1, "R7 write 1 keeps", d[1], 1);
        sys_reset(); rd(1'b0, d); chk(d[1] == 1'b1, "R7 rst_n keeps flag", d[1], 1);
        wr(1'b0, 8'h00); rd(1'b0, d); chk(d[1] == 1'b0, "R7 write 0 clears", d[1], 0);

        // R4: service partway through
        start_wd();
        repeat (10) @(posedge clk); #1;
        chk(wdt_rst_o == 1'b0, "R4 no early request", wdt_rst_o, 0);
        start_wd();
        run_check(period(0), 1'b0, 1'b0, 1'b0, "R4 restarted count");
        wr(1'b0, 8'h00);

        // R8: rst_n disables and drops the armed state
        start_wd(); sys_reset();
        rd(1'b0, d); chk(d[0] == 1'b0, "R8 rst_n disables", d[0], 0);
        wr(1'b1, 8'h1E); sys_reset(); wr(1'b1, 8'hE1);
        bad_check("R8 armed state dropped");
        wr(1'b0, 8'h00);

        // R5: bad keys
        wr(1'b1, 8'h55); bad_check("R5 bad while idle"); wr(1'b0, 8'h00);
        wr(1'b1, 8'hE1); bad_check("R5 lone second key"); wr(1'b0, 8'h00);
        start_wd(); wr(1'b1, 8'h1E); wr(1'b1, 8'h1E);
        bad_check("R5 wrong second key"); wr(1'b0, 8'h00);

        // R6: freeze holds, no freeze counts during idle
        wr(1'b0, 8'h10); start_wd();
        idle_i = 1'b1;
        for (int k = 0; k < 40; k++) begin
            @(posedge clk); #1;
            chk(wdt_rst_o == 1'b0, "R6 frozen", wdt_rst_o, 0);
        end
        run_check(period(0), 1'b1, 1'b0, 1'b0, "R6 resumes after idle");
        wr(1'b0, 8'h00); start_wd();
        run_check(period(0), 1'b0, 1'b0, 1'b1, "R6 counts in idle");

        // R3: largest prescaler
        wr(1'b0, 8'hE0); start_wd();
        run_check(period(7), 1'b0, 1'b0, 1'b0, "R3 timeout ps7");

        // R3 and R6: random prescaler, freeze and idle patterns
        for (int it = 0; it < 24; it++) begin
            int  ps  = int'($urandom % 4);
            bit  frz = 1'($urandom % 2);
            wr(1'b0, {3'(ps), frz, 4'b0000});
            start_wd();
            run_check(period(ps), frz, 1'b1, 1'b0, "R3 R6 random");
        end

        // R1: power-on reset clears the flag
        @(negedge clk); por_n = 1'b0; @(negedge clk); por_n = 1'b1;
        rd(1'b0, d); chk(d == 8'h00, "R1 R7 por clears", d, 8'h00);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule